// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of an Ethernet MAC's DMA engine. It holds a ring of two-word descriptors in a small on-chip store and accepts frame bytes on a valid/ready byte stream that has a last-byte flag. It carves each frame into fixed-size receive buffers, using one descriptor per buffer. Each payload byte is presented as a buffer address/data write strobe. When a buffer closes, the block writes ownership and status back into that buffer's descriptor.

Software loads buffer addresses into the descriptor store through a word-wide write port. It reads descriptors back through the same port and hands a buffer back by clearing its ownership bit. A separate strobe sets the ring base index. Every descriptor is an address word followed by a status word. In the address word, bit 0 is the ownership (used) flag and bit 1 is the wrap flag. The buffer base address is the address word with these two flag bits cleared.

Top module: `rx_ring_writer`

## Requirements
- R1: While reset is held, in_ready is 0 and every descriptor word reads as zero. From the first clock edge after reset is released, in_ready is 1.
- R2: An accepted byte written into a buffer appears one cycle later with buf_we high. buf_addr is the buffer base (address word with bits 1:0 cleared) plus the byte's offset in that buffer, and buf_data is the byte.
- R3: A buffer holds exactly BUF_BYTES (default 128) bytes. The next byte of the frame goes to offset 0 of the next descriptor's buffer.
- R4: The status word of the descriptor that receives a frame's first byte has bit 14 set. The status word of the descriptor that receives the last byte has bit 15 set. A frame that fits in one buffer has both bits set.
- R5: In the end-of-frame descriptor, status bits 11:0 hold the frame's byte count. A descriptor closed before the end of a frame has bits 11:0 and bit 31 zero.
- R6: When a buffer closes, the engine sets bit 0 of its descriptor's address word and leaves all other address bits unchanged.
- R7: After the engine closes a descriptor whose address word has bit 1 set, the next buffer is the ring base descriptor, even in the middle of a frame. Otherwise the next buffer is the next index, modulo the ring size.
- R8: Bit 31 of the end-of-frame status word equals in_bcast as sampled with the frame's first byte.
- R9: If a buffer is due to start at a descriptor whose bit 0 is already set, bna_pulse is high for one cycle, one cycle after that byte is accepted. That byte and the rest of the frame produce no buffer writes and change no descriptor. The next frame tries the same descriptor again.
- R10: If a software write and an engine write-back hit the same descriptor word in the same cycle, the engine's value is stored. A software write to a different word in that cycle still takes effect.
- R11: base_we makes base_idx the ring base and the next descriptor to fill. A wrap flag then returns the engine to that index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software descriptor word write strobe |
| sw_addr | input | WORD_AW | Descriptor word index (2*desc = address word, 2*desc+1 = status word) |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Descriptor word at sw_addr |
| base_we | input | 1 | Load ring base and fill pointer |
| base_idx | input | IDX_W | Ring base descriptor index |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_bcast | input | 1 | Broadcast destination indication, sampled with first byte |
| buf_we | output | 1 | Buffer payload write strobe |
| buf_addr | output | 32 | Buffer payload byte address |
| buf_data | output | 8 | Buffer payload byte |
| bna_pulse | output | 1 | Buffer-not-available event |

## Verification
In a single cycle, the engine's descriptor write-back can coincide with a software write to the descriptor store. The bench provokes this by issuing a software write on the same cycle as the last byte of a frame. In one frame the write targets the status word being written back. In another it targets an unrelated address word. The results are judged by reading both words back: the engine's status must survive the first collision, and the software value must land in the second. Ownership checks at buffer start also read the store in a cycle where software may be changing it. The bench's behavioural model, which runs every clock, decides those cycles from the value held before the edge.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int USED_POS  = 0;
  localparam int WRAP_POS  = 1;
  localparam int SOF_POS   = 14;
  localparam int EOF_POS   = 15;
  localparam int BCAST_POS = 31;
  localparam int LEN_W     = 12;

  // Status word for a closing buffer; length and broadcast only on end of frame.
  function automatic logic [31:0] pack_status(input logic sof, input logic eof,
                                              input logic bcast,
                                              input logic [LEN_W-1:0] len);
    logic [31:0] s;
    s = '0;
    s[SOF_POS] = sof;
    s[EOF_POS] = eof;
    if (eof) begin
      s[BCAST_POS]   = bcast;
      s[LEN_W-1:0]   = len;
    end
    return s;
  endfunction

  // Buffer base: address word with both flag bits masked.
  function automatic logic [31:0] buf_base(input logic [31:0] aw);
    return {aw[31:2], 2'b00};
  endfunction

  // Address word handed back with ownership taken by the engine.
  function automatic logic [31:0] mark_used(input logic [31:0] aw);
    logic [31:0] r;
    r = aw;
    r[USED_POS] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/rxr_desc_store.sv
module rxr_desc_store #(
  parameter int NDESC = 8,
  parameter int IDX_W = 3,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [AW-1:0]    sw_addr,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [31:0]      eng_addr_w,
  input  logic [31:0]      eng_stat_w,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_addr_w
);
  localparam int NWORDS = 2 * NDESC;

  logic [31:0] words [NWORDS];

  // Engine write-back is applied after the software write so it wins on a clash.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) words[i] <= '0;
    end else begin
      if (sw_we) words[sw_addr] <= sw_wdata;
      if (eng_we) begin
        words[{eng_idx, 1'b0}] <= eng_addr_w;
        words[{eng_idx, 1'b1}] <= eng_stat_w;
      end
    end
  end

  assign sw_rdata  = words[sw_addr];
  assign rd_addr_w = words[{rd_idx, 1'b0}];
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int NDESC = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [IDX_W-1:0] base_idx,
  input  logic             adv,
  input  logic             wrap_here,
  output logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] base_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NDESC - 1);

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] cur,
                                            input logic wrap,
                                            input logic [IDX_W-1:0] base);
    if (wrap)        return base;
    else if (cur == LAST) return '0;
    else             return cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      base_q <= '0;
    end else if (base_we) begin
      ptr    <= base_idx;
      base_q <= base_idx;
    end else if (adv) begin
      ptr    <= step(ptr, wrap_here, base_q);
    end
  end
endmodule

// File: rtl/rxr_fill_ctrl.sv
module rxr_fill_ctrl
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int OFF_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_bcast,
  input  logic [31:0]      cur_addr_w,
  output logic             in_ready,
  output logic             buf_we,
  output logic [31:0]      buf_addr,
  output logic [7:0]       buf_data,
  output logic             bna_pulse,
  output logic             take_ev,
  output logic             close_ev,
  output logic             dropping,
  output logic [OFF_W-1:0] offset,
  output logic [31:0]      eng_addr_w,
  output logic [31:0]      eng_stat_w
);
  logic             rdy_q, drop_q, mid_q, done_q, bc_q;
  logic [OFF_W-1:0] off_q;
  logic [LEN_W-1:0] len_q;

  logic             accept, at_start, cur_used, buf_full, bc_eff, no_buf_ev;
  logic [LEN_W-1:0] len_nx;

  assign accept    = in_valid & rdy_q;
  assign at_start  = (off_q == '0);
  assign cur_used  = cur_addr_w[USED_POS];
  assign no_buf_ev = accept & ~drop_q & at_start & cur_used;
  assign take_ev   = accept & ~drop_q & ~no_buf_ev;
  assign buf_full  = (off_q == OFF_W'(BUF_BYTES - 1));
  assign close_ev  = take_ev & (buf_full | in_last);
  assign bc_eff    = mid_q ? bc_q : in_bcast;
  assign len_nx    = len_q + 1'b1;

  assign eng_addr_w = mark_used(cur_addr_w);
  assign eng_stat_w = pack_status(~done_q, in_last, bc_eff, len_nx);

  assign in_ready = rdy_q;
  assign dropping = drop_q;
  assign offset   = off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      drop_q    <= 1'b0;
      mid_q     <= 1'b0;
      done_q    <= 1'b0;
      bc_q      <= 1'b0;
      off_q     <= '0;
      len_q     <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_data  <= '0;
      bna_pulse <= 1'b0;
    end else begin
      rdy_q     <= 1'b1;
      buf_we    <= take_ev;
      bna_pulse <= no_buf_ev;
      if (take_ev) begin
        buf_addr <= buf_base(cur_addr_w) + 32'(off_q);
        buf_data <= in_data;
      end
      if (accept) begin
        mid_q  <= ~in_last;
        len_q  <= in_last ? '0 : len_nx;
        if (!mid_q) bc_q <= in_bcast;
        drop_q <= drop_q ? ~in_last : (no_buf_ev & ~in_last);
      end
      if (accept & in_last) done_q <= 1'b0;
      else if (close_ev)    done_q <= 1'b1;
      if (base_we)       off_q <= '0;
      else if (close_ev) off_q <= '0;
      else if (take_ev)  off_q <= off_q + 1'b1;
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter  int NDESC     = 8,
  parameter  int BUF_BYTES = 128,
  localparam int IDX_W     = $clog2(NDESC),
  localparam int WORD_AW   = IDX_W + 1,
  localparam int OFF_W     = $clog2(BUF_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_we,
  input  logic [WORD_AW-1:0] sw_addr,
  input  logic [31:0]        sw_wdata,
  output logic [31:0]        sw_rdata,
  input  logic               base_we,
  input  logic [IDX_W-1:0]   base_idx,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  input  logic               in_bcast,
  output logic               buf_we,
  output logic [31:0]        buf_addr,
  output logic [7:0]         buf_data,
  output logic               bna_pulse
);
  // Named internal events, also observed by the bound checker.
  logic [IDX_W-1:0] ptr, base_q;
  logic [31:0]      cur_addr_w, eng_addr_w, eng_stat_w;
  logic             take_ev, close_ev, dropping, cur_wrap, cur_used;
  logic [OFF_W-1:0] offset;

  assign cur_wrap = cur_addr_w[WRAP_POS];
  assign cur_used = cur_addr_w[USED_POS];

  rxr_desc_store #(.NDESC(NDESC), .IDX_W(IDX_W), .AW(WORD_AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .eng_we(close_ev), .eng_idx(ptr), .eng_addr_w(eng_addr_w), .eng_stat_w(eng_stat_w),
    .rd_idx(ptr), .rd_addr_w(cur_addr_w)
  );

  rxr_ring_ptr #(.NDESC(NDESC), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_idx(base_idx),
    .adv(close_ev), .wrap_here(cur_wrap),
    .ptr(ptr), .base_q(base_q)
  );

  rxr_fill_ctrl #(.BUF_BYTES(BUF_BYTES), .OFF_W(OFF_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .base_we(base_we),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_bcast(in_bcast),
    .cur_addr_w(cur_addr_w),
    .in_ready(in_ready), .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .bna_pulse(bna_pulse), .take_ev(take_ev), .close_ev(close_ev),
    .dropping(dropping), .offset(offset),
    .eng_addr_w(eng_addr_w), .eng_stat_w(eng_stat_w)
  );
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int IDX_W     = 3,
  parameter int OFF_W     = 7,
  parameter int BUF_BYTES = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             base_we,
  input logic             buf_we,
  input logic             bna_pulse,
  input logic             take_ev,
  input logic             close_ev,
  input logic             dropping,
  input logic             cur_wrap,
  input logic             cur_used,
  input logic [IDX_W-1:0] ptr,
  input logic [IDX_W-1:0] base_q,
  input logic [OFF_W-1:0] offset
);
  // R2: a byte taken into a buffer is strobed out on the next cycle.
  p_take_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> buf_we);

  // R3: the byte filling the final slot always closes the buffer.
  p_full_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && offset == OFF_W'(BUF_BYTES - 1)) |-> close_ev);

  // R6: a buffer is never started on a descriptor the engine still owns.
  p_start_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && offset == '0) |-> !cur_used);

  // R7: closing a wrap descriptor returns to the ring base.
  p_wrap_to_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (close_ev && cur_wrap && !base_we) |=> (ptr == $past(base_q)));

  // R9: a buffer-not-available event never comes with a payload write.
  p_bna_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bna_pulse |-> !buf_we);

  // R9: while a frame is dropped the fill pointer stays put.
  p_drop_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dropping && !base_we) |=> $stable(ptr));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(
  .IDX_W(IDX_W), .OFF_W(OFF_W), .BUF_BYTES(BUF_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .base_we(base_we), .buf_we(buf_we),
  .bna_pulse(bna_pulse), .take_ev(take_ev), .close_ev(close_ev),
  .dropping(dropping), .cur_wrap(cur_wrap), .cur_used(cur_used),
  .ptr(ptr), .base_q(base_q), .offset(offset)
);

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/1ps
module rx_ring_writer_test;
  localparam int ND = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        sw_we = 1'b0;
  logic [3:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic        base_we = 1'b0;
  logic [2:0]  base_idx = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_bcast = 1'b0;
  wire  [31:0] sw_rdata;
  wire         in_ready, buf_we, bna_pulse;
  wire  [31:0] buf_addr;
  wire  [7:0]  buf_data;

  rx_ring_writer uut (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .base_we(base_we), .base_idx(base_idx),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_bcast(in_bcast), .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .bna_pulse(bna_pulse)
  );

  int checks = 0;
  int errors = 0;
  int bna_seen = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: descriptor words, fill pointer, buffer offset.
  logic [31:0] m [16];
  int  p, bs, off, cnt, nbuf;
  bit  drop, first, bc, mw, mb, mr, close;
  logic [31:0] ma, a_old, st;
  logic [7:0]  md;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m[i] = '0;
      p = 0; bs = 0; off = 0; cnt = 0; nbuf = 0;
      drop = 0; first = 1; bc = 0; mw = 0; mb = 0; mr = 0;
      ma = '0; md = '0; st = '0;
    end else begin
      a_old = m[2*p];
      close = 0; mw = 0; mb = 0;
      if (in_valid && mr) begin
        if (first) bc = in_bcast;
        cnt++;
        if (drop) begin
          if (in_last) drop = 0;
        end else if (off == 0 && a_old[0]) begin
          mb = 1;
          if (!in_last) drop = 1;
        end else begin
          mw = 1;
          ma = (a_old & ~32'h3) + 32'(off);
          md = in_data;
          off++;
          if (off == 128 || in_last) begin
            close = 1;
            st = (nbuf == 0) ? 32'h0000_4000 : 32'h0;
            if (in_last) st = st | 32'h0000_8000 | (bc ? 32'h8000_0000 : 32'h0)
                              | (32'(cnt) & 32'hfff);
          end
        end
        first = in_last;
        if (in_last) cnt = 0;
      end
      if (sw_we) m[sw_addr] = sw_wdata;
      if (close) begin
        m[2*p]   = a_old | 32'h1;
        m[2*p+1] = st;
        off  = 0;
        nbuf = in_last ? 0 : nbuf + 1;
        p    = a_old[1] ? bs : (p + 1) % ND;
      end else if (in_valid && mr && in_last) begin
        nbuf = 0;
      end
      if (base_we) begin
        p = int'(base_idx); bs = int'(base_idx); off = 0;
      end
      mr = 1;
    end
  end

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready === mr, "R1 ready", 32'(in_ready), 32'(mr));
      chk(buf_we === mw, "R2 buf_we", 32'(buf_we), 32'(mw));
      if (mw) begin
        chk(buf_addr === ma, "R2 buf_addr", buf_addr, ma);
        chk(buf_data === md, "R2 buf_data", 32'(buf_data), 32'(md));
      end
      chk(bna_pulse === mb, "R9 bna_pulse", 32'(bna_pulse), 32'(mb));
      chk(sw_rdata === m[sw_addr], "R6 descriptor word", sw_rdata, m[sw_addr]);
      if (bna_pulse) bna_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int w, input logic [31:0] d);
    @(posedge clk); #1;
    sw_we = 1'b1; sw_addr = 4'(w); sw_wdata = d;
    @(posedge clk); #1;
    sw_we = 1'b0;
  endtask

  task automatic rd(input int w, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    sw_addr = 4'(w);
    @(negedge clk);
    chk(sw_rdata === e, tag, sw_rdata, e);
  endtask

  task automatic set_base(input int b);
    @(posedge clk); #1;
    base_we = 1'b1; base_idx = 3'(b);
    @(posedge clk); #1;
    base_we = 1'b0;
  endtask

  // Send n bytes; on byte k also issue a software write of sd to word sa.
  task automatic send(input int n, input bit bcv, input int k, input int sa,
                      input logic [31:0] sd);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_data  = 8'(i * 7 + n);
      in_last  = (i == n - 1);
      in_bcast = bcv;
      if (i == k) begin
        sw_we = 1'b1; sw_addr = 4'(sa); sw_wdata = sd;
      end else begin
        sw_we = 1'b0;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; sw_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready === 1'b0, "R1 ready in reset", 32'(in_ready), 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd(0, 32'h0, "R1 word0 reset");
    rd(5, 32'h0, "R1 word5 reset");
    rd(15, 32'h0, "R1 word15 reset");

    for (int i = 0; i < ND; i++)
      wr(2*i, 32'h8000_0000 + 32'(i << 8) + ((i == 5) ? 32'h2 : 32'h0));
    set_base(2);

    // Frame A: single buffer, broadcast.
    send(60, 1'b1, -1, 0, 32'h0);
    rd(4, 32'h8000_0201, "R6 used set A");
    rd(5, 32'h8000_C03C, "R4 sof eof A");
    chk(sw_rdata[31] === 1'b1, "R8 broadcast A", 32'(sw_rdata[31]), 32'h1);

    // Frame B: three buffers ending on the wrap descriptor.
    send(300, 1'b0, -1, 0, 32'h0);
    rd(7, 32'h0000_4000, "R4 sof only B");
    rd(9, 32'h0000_0000, "R3 middle buffer B");
    rd(11, 32'h0000_812C, "R5 length B");
    rd(10, 32'h8000_0503, "R6 wrap kept B");

    // Frame C: pointer back at base, descriptor still owned.
    send(128, 1'b0, -1, 0, 32'h0);
    rd(5, 32'h8000_C03C, "R9 untouched C");

    // Frame D: exactly one full buffer.
    wr(4, 32'h8000_0200);
    send(128, 1'b0, -1, 0, 32'h0);
    rd(5, 32'h0000_C080, "R3 full buffer D");

    // Frame E: wraps from the last descriptor to base mid-frame.
    wr(6, 32'h8000_0300); wr(8, 32'h8000_0400); wr(10, 32'h8000_0502);
    wr(4, 32'h8000_0200);
    send(400, 1'b1, -1, 0, 32'h0);
    rd(7, 32'h0000_4000, "R4 sof E");
    rd(11, 32'h0000_0000, "R5 no length mid E");
    rd(5, 32'h8000_8190, "R7 mid-frame wrap E");

    // Frame F: second buffer not available.
    wr(6, 32'h8000_0300);
    send(200, 1'b0, -1, 0, 32'h0);
    rd(7, 32'h0000_4000, "R9 partial F");
    rd(8, 32'h8000_0401, "R9 owned kept F");

    // Frame G: software hits the status word being written back.
    wr(8, 32'h8000_0400); wr(10, 32'h8000_0502);
    send(10, 1'b0, 9, 9, 32'hDEAD_BEEF);
    rd(9, 32'h0000_C00A, "R10 engine wins G");

    // Frame H: software writes another word in the write-back cycle.
    send(5, 1'b1, 4, 4, 32'h8000_0200);
    rd(4, 32'h8000_0200, "R10 other word H");
    rd(11, 32'h8000_C005, "R8 broadcast H");

    // New base: a one-descriptor ring.
    wr(12, 32'h8000_0602);
    set_base(6);
    send(3, 1'b0, -1, 0, 32'h0);
    rd(13, 32'h0000_C003, "R11 base fill");
    rd(12, 32'h8000_0603, "R11 base used");
    send(1, 1'b0, -1, 0, 32'h0);
    repeat (2) @(negedge clk);
    chk(bna_seen == 3, "R9 bna count", 32'(bna_seen), 32'h3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule